// File: doc/BRIEF.md
# Push-button power on/off sequencer

This block decides when system power is enabled. It watches an active-low push button, a digitized active-low undervoltage flag and an active-low kill line from the host processor. All timing is counted in ticks of a 1 ms timebase strobe, so the block runs from any core clock. A press held long enough while power is off turns power on. A press or an undervoltage episode while power is on first raises an active-low interrupt so the processor can shut down in order and answer through the kill line. If the request is held long enough, power is cut without waiting for the processor.

After power comes up, a blanking window gives the host time to boot and drive kill high. Every input is ignored during this window, and if kill is still low when it ends the power-on is aborted. Only one of button and undervoltage can own a shutdown request at a time. While power is off, an undervoltage condition keeps the button from turning power on. After every release, a lockout period ignores the button. A parameter chooses whether the enable output is active high or active low.

Top module: `pbtn_power_seq`

## Requirements
- R1: While reset is asserted and after it is released, power is off: `en_o` is at its inactive level and `int_no` is high.
- R2: With power off and `uvlo_ni` high, `pb_ni` held low for 32 consecutive ticks turns power on at the 32nd tick. If the button goes high before then, the count restarts from zero.
- R3: The blanking window starts when power turns on and lasts 512 ticks. Button, undervoltage and kill are all ignored during it. If kill is low at the 512th tick, power turns off. Otherwise power stays on.
- R4: After the blanking window, kill low turns power off within four clocks. This applies with or without a pending interrupt.
- R5: After the blanking window, if the owning input stays low for 32 ticks, `int_no` goes low. It stays low for at least 32 ticks, and for as long as the owning input is held. A low pulse shorter than 32 ticks leaves `int_no` high.
- R6: If the owning input stays low for 64 + `extra_ms_i` ticks, counted from its first low tick, power turns off and `int_no` returns high on that tick. With `extra_ms_i` = 0 this happens at exactly 64 ticks.
- R7: When the block is idle and both inputs fall together, the button owns the request. Once an input owns the request, the other input has no effect until the owner releases or power goes off.
- R8: While power is off, `uvlo_ni` low keeps the button from turning power on. The 32-tick count begins only once `uvlo_ni` is high.
- R9: After each power-off there is a 64-tick lockout in which the button is ignored. A button held low throughout the lockout turns power on 64 + 32 ticks after the release.
- R10: With `EN_ACT_HIGH` = 1, `en_o` is high when power is on. With `EN_ACT_HIGH` = 0, `en_o` is the inverse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle 1 ms timebase strobe |
| pb_ni | input | 1 | Push button, low when pressed (asynchronous) |
| uvlo_ni | input | 1 | Undervoltage flag, low when supply is low (asynchronous) |
| kill_ni | input | 1 | Host power-kill request, active low (asynchronous) |
| extra_ms_i | input | EXTRA_W | Extra forced-off hold time in ticks, added to 64 |
| en_o | output | 1 | Power enable, polarity set by EN_ACT_HIGH |
| int_no | output | 1 | Shutdown interrupt to host, active low |

## Verification
The hardest situations to reach are the exact tick boundaries: the forced power-off at 64 + extra ticks, and the blanking-window abort at 512 ticks. They must be hit while the non-owning input is toggling and the button is still held across the release and the lockout. The stimulus changes inputs only just after a timebase tick, so the two-flop synchronizers settle before the next tick. This lets the expected turn-on and turn-off be placed on a known tick count and sampled one tick early and on the tick. Random sub-threshold pulses on both inputs, with power off and with power on, test the restart of the debounce count.

// File: rtl/pps_pkg.sv
package pps_pkg;
  typedef enum logic [2:0] {
    PS_OFF   = 3'd0,
    PS_BLANK = 3'd1,
    PS_ON    = 3'd2,
    PS_INT   = 3'd3,
    PS_LOCK  = 3'd4
  } pwr_state_e;

  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_PB   = 2'd1,
    OWN_UV   = 2'd2
  } owner_e;
endpackage

// File: rtl/pps_sync.sv
module pps_sync #(
  parameter int unsigned     WIDTH   = 1,
  parameter int unsigned     STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= {STAGES{RST_VAL}};
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/pps_timer.sv
module pps_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_o <= '0;
    else if (clr_i)   cnt_o <= {{(W-1){1'b0}}, inc_i};
    else if (inc_i)   cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/pps_fsm.sv
module pps_fsm
  import pps_pkg::*;
#(
  parameter int unsigned DEB_T   = 32,
  parameter int unsigned BLANK_T = 512,
  parameter int unsigned PD_T    = 64,
  parameter int unsigned LOCK_T  = 64,
  parameter int unsigned INT_T   = 32,
  parameter int unsigned EXTRA_W = 12,
  parameter int unsigned TW      = 13,
  parameter int unsigned IW      = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               pb_s_i,
  input  logic               uv_s_i,
  input  logic               kill_s_i,
  input  logic [EXTRA_W-1:0] extra_i,
  input  logic [TW-1:0]      m_cnt_i,
  input  logic [IW-1:0]      i_cnt_i,
  output logic               m_clr_o,
  output logic               m_inc_o,
  output logic               i_clr_o,
  output logic               i_inc_o,
  output pwr_state_e         state_o,
  output owner_e             owner_o,
  output logic               pwr_on_o,
  output logic               int_act_o
);
  localparam logic [TW-1:0] DEB_LAST   = TW'(DEB_T - 1);
  localparam logic [TW-1:0] BLANK_LAST = TW'(BLANK_T - 1);
  localparam logic [TW-1:0] LOCK_LAST  = TW'(LOCK_T - 1);
  localparam logic [IW-1:0] INT_FULL   = IW'(INT_T);

  pwr_state_e st_q, st_d;
  owner_e     own_q, own_d;
  logic       rel_q, rel_d;
  logic       owner_low;
  logic [TW-1:0] pd_last;

  assign pd_last = TW'(PD_T) + TW'(extra_i) - 1'b1;

  always_comb begin
    unique case (own_q)
      OWN_PB:  owner_low = !pb_s_i;
      OWN_UV:  owner_low = !uv_s_i;
      default: owner_low = 1'b0;
    endcase
  end

  always_comb begin
    st_d    = st_q;
    own_d   = own_q;
    rel_d   = rel_q;
    m_clr_o = 1'b0;
    m_inc_o = 1'b0;
    i_clr_o = 1'b0;
    i_inc_o = 1'b0;
    unique case (st_q)
      PS_OFF: begin
        if (!pb_s_i && uv_s_i) begin
          m_inc_o = tick_i;
          if (tick_i && m_cnt_i == DEB_LAST) begin
            st_d    = PS_BLANK;
            m_clr_o = 1'b1;
            m_inc_o = 1'b0;
          end
        end else begin
          m_clr_o = 1'b1;
        end
      end
      PS_BLANK: begin
        m_inc_o = tick_i;
        if (tick_i && m_cnt_i == BLANK_LAST) begin
          m_clr_o = 1'b1;
          m_inc_o = 1'b0;
          st_d    = kill_s_i ? PS_ON : PS_LOCK;
        end
      end
      PS_ON: begin
        if (!kill_s_i) begin
          st_d    = PS_LOCK;
          own_d   = OWN_NONE;
          m_clr_o = 1'b1;
        end else if (own_q == OWN_NONE) begin
          // button wins a simultaneous claim
          if (!pb_s_i)      own_d = OWN_PB;
          else if (!uv_s_i) own_d = OWN_UV;
          if (!pb_s_i || !uv_s_i) begin
            m_clr_o = 1'b1;
            m_inc_o = tick_i;
          end
        end else if (!owner_low) begin
          own_d   = OWN_NONE;
          m_clr_o = 1'b1;
        end else begin
          m_inc_o = tick_i;
          if (tick_i && m_cnt_i == DEB_LAST) begin
            st_d    = PS_INT;
            i_clr_o = 1'b1;
            rel_d   = 1'b0;
          end
        end
      end
      PS_INT: begin
        if (!kill_s_i) begin
          st_d    = PS_LOCK;
          own_d   = OWN_NONE;
          m_clr_o = 1'b1;
        end else if (!rel_q && owner_low && tick_i && m_cnt_i == pd_last) begin
          st_d    = PS_LOCK;
          own_d   = OWN_NONE;
          m_clr_o = 1'b1;
        end else begin
          i_inc_o = tick_i && (i_cnt_i != INT_FULL);
          if (!rel_q) begin
            if (owner_low) m_inc_o = tick_i;
            else           rel_d   = 1'b1;
          end
          if (rel_q && i_cnt_i == INT_FULL) begin
            st_d    = PS_ON;
            own_d   = OWN_NONE;
            m_clr_o = 1'b1;
          end
        end
      end
      PS_LOCK: begin
        m_inc_o = tick_i;
        if (tick_i && m_cnt_i == LOCK_LAST) begin
          st_d    = PS_OFF;
          m_clr_o = 1'b1;
          m_inc_o = 1'b0;
        end
      end
      default: begin
        st_d    = PS_OFF;
        own_d   = OWN_NONE;
        m_clr_o = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= PS_OFF;
      own_q     <= OWN_NONE;
      rel_q     <= 1'b0;
      pwr_on_o  <= 1'b0;
      int_act_o <= 1'b0;
    end else begin
      st_q      <= st_d;
      own_q     <= own_d;
      rel_q     <= rel_d;
      pwr_on_o  <= (st_d == PS_BLANK) || (st_d == PS_ON) || (st_d == PS_INT);
      int_act_o <= (st_d == PS_INT);
    end
  end

  assign state_o = st_q;
  assign owner_o = own_q;
endmodule

// File: rtl/pbtn_power_seq.sv
module pbtn_power_seq
  import pps_pkg::*;
#(
  parameter int unsigned DEB_MS      = 32,
  parameter int unsigned BLANK_MS    = 512,
  parameter int unsigned PD_MS       = 64,
  parameter int unsigned LOCK_MS     = 64,
  parameter int unsigned INT_MIN_MS  = 32,
  parameter int unsigned EXTRA_W     = 12,
  parameter int unsigned SYNC_STAGES = 2,
  parameter bit          EN_ACT_HIGH = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               pb_ni,
  input  logic               uvlo_ni,
  input  logic               kill_ni,
  input  logic [EXTRA_W-1:0] extra_ms_i,
  output logic               en_o,
  output logic               int_no
);
  localparam int unsigned PD_MAX  = PD_MS + (1 << EXTRA_W);
  localparam int unsigned CNT_MAX = (BLANK_MS > PD_MAX) ? BLANK_MS : PD_MAX;
  localparam int unsigned TW      = $clog2(CNT_MAX + 1);
  localparam int unsigned IW      = $clog2(INT_MIN_MS + 1);

  logic          pb_s, uv_s, kill_s;
  logic [2:0]    raw_in, syn_in;
  logic          m_clr, m_inc, i_clr, i_inc;
  logic [TW-1:0] m_cnt;
  logic [IW-1:0] i_cnt;
  pwr_state_e    st;
  owner_e        own;
  logic          pwr_on, int_act;

  assign raw_in = {kill_ni, uvlo_ni, pb_ni};

  pps_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_in),
    .q_o   (syn_in)
  );

  assign pb_s   = syn_in[0];
  assign uv_s   = syn_in[1];
  assign kill_s = syn_in[2];

  pps_timer #(.W(TW)) u_tmr_main (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (m_clr),
    .inc_i (m_inc),
    .cnt_o (m_cnt)
  );

  pps_timer #(.W(IW)) u_tmr_int (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (i_clr),
    .inc_i (i_inc),
    .cnt_o (i_cnt)
  );

  pps_fsm #(
    .DEB_T  (DEB_MS),
    .BLANK_T(BLANK_MS),
    .PD_T   (PD_MS),
    .LOCK_T (LOCK_MS),
    .INT_T  (INT_MIN_MS),
    .EXTRA_W(EXTRA_W),
    .TW     (TW),
    .IW     (IW)
  ) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .pb_s_i   (pb_s),
    .uv_s_i   (uv_s),
    .kill_s_i (kill_s),
    .extra_i  (extra_ms_i),
    .m_cnt_i  (m_cnt),
    .i_cnt_i  (i_cnt),
    .m_clr_o  (m_clr),
    .m_inc_o  (m_inc),
    .i_clr_o  (i_clr),
    .i_inc_o  (i_inc),
    .state_o  (st),
    .owner_o  (own),
    .pwr_on_o (pwr_on),
    .int_act_o(int_act)
  );

  generate
    if (EN_ACT_HIGH) begin : g_en_hi
      assign en_o = pwr_on;
    end else begin : g_en_lo
      assign en_o = ~pwr_on;
    end
  endgenerate

  assign int_no = ~int_act;
endmodule

// File: rtl/pps_chk.sv
module pps_chk
  import pps_pkg::*;
#(
  parameter bit EN_ACT_HIGH = 1'b1
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       en_o,
  input logic       int_no,
  input pwr_state_e state_i,
  input owner_e     owner_i,
  input logic       pb_s_i,
  input logic       uv_s_i,
  input logic       kill_s_i
);
  logic on_w;
  assign on_w = (en_o == EN_ACT_HIGH);

  assert_reset_off_R1: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (!on_w && int_no));

  assert_on_from_off_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(on_w) |-> ($past(state_i) == PS_OFF && !$past(pb_s_i)));

  assert_abort_needs_kill_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(on_w) && $past(state_i) == PS_BLANK) |-> !$past(kill_s_i));

  assert_kill_drops_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_i == PS_ON || state_i == PS_INT) && !kill_s_i) |=> !on_w);

  assert_int_only_on_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !int_no |-> on_w);

  assert_owner_held_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == PS_INT && $past(state_i) == PS_INT) |-> $stable(owner_i));

  assert_uv_blocks_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(on_w) |-> $past(uv_s_i));

  assert_lock_exit_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == PS_LOCK |=> (state_i == PS_LOCK || state_i == PS_OFF));
endmodule

bind pbtn_power_seq pps_chk #(.EN_ACT_HIGH(EN_ACT_HIGH)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .en_o    (en_o),
  .int_no  (int_no),
  .state_i (st),
  .owner_i (own),
  .pb_s_i  (pb_s),
  .uv_s_i  (uv_s),
  .kill_s_i(kill_s)
);

// File: tb/sim_pbtn_power_seq.sv
`timescale 1ns/1ps
module sim_pbtn_power_seq;
  localparam int unsigned EXTRA_W = 12;
  localparam int unsigned WD_CYC  = 120000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick;
  logic pb_n = 1'b1, uv_n = 1'b1, kill_n = 1'b0;
  logic [EXTRA_W-1:0] extra = '0;
  logic en0, int0, en1, int1;
  logic [1:0] div;
  int n_chk = 0, n_bad = 0;
  bit wd_hit = 1'b0;

  always #2.5 clk = ~clk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div  <= '0;
      tick <= 1'b0;
    end else begin
      div  <= div + 1'b1;
      tick <= (div == 2'd2);
    end
  end

  pbtn_power_seq #(.EN_ACT_HIGH(1'b1)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .pb_ni(pb_n), .uvlo_ni(uv_n),
    .kill_ni(kill_n), .extra_ms_i(extra), .en_o(en0), .int_no(int0));

  pbtn_power_seq #(.EN_ACT_HIGH(1'b0)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .pb_ni(pb_n), .uvlo_ni(uv_n),
    .kill_ni(kill_n), .extra_ms_i(extra), .en_o(en1), .int_no(int1));

  function automatic logic exp_en(bit on, bit act_hi);
    return act_hi ? on : !on;
  endfunction

  task automatic chk(string req, string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s act=%0b exp=%0b", req, what, act, exp);
    end
  endtask

  task automatic chk_pwr(string req, bit on, bit irq);
    chk(req, "en_o(high)", en0, exp_en(on, 1'b1));
    chk(req, "int_no", int0, !irq);
    chk("R10", "en_o(low variant)", en1, exp_en(on, 1'b0));
    chk("R10", "int_no(low variant)", int1, !irq);
  endtask

  task automatic ticks(int n);
    repeat (n) begin
      do @(posedge clk); while (!tick);
    end
  endtask

  task automatic settle();
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run();
    repeat (5) @(negedge clk);
    chk_pwr("R1", 1'b0, 1'b0);
    rst_n = 1'b1;
    ticks(40); settle();
    chk_pwr("R1", 1'b0, 1'b0);

    // R2: short presses while off restart the count
    for (int i = 0; i < 6; i++) begin
      pb_n = 1'b0; ticks(1 + ($urandom % 30)); settle();
      chk_pwr("R2", 1'b0, 1'b0);
      pb_n = 1'b1; ticks(2); settle();
    end
    pb_n = 1'b0; ticks(31); settle();
    chk_pwr("R2", 1'b0, 1'b0);
    ticks(1); settle();
    chk_pwr("R2", 1'b1, 1'b0);

    // R3: inputs ignored in blanking, kill low at the end aborts
    ticks(100); settle();
    pb_n = 1'b1; uv_n = 1'b0;
    ticks(50); settle();
    chk_pwr("R3", 1'b1, 1'b0);
    uv_n = 1'b1;
    ticks(361); settle();
    chk_pwr("R3", 1'b1, 1'b0);
    ticks(1); settle();
    chk_pwr("R3", 1'b0, 1'b0);

    // R9: button held through lockout
    pb_n = 1'b0;
    ticks(95); settle();
    chk_pwr("R9", 1'b0, 1'b0);
    ticks(1); settle();
    chk_pwr("R9", 1'b1, 1'b0);
    kill_n = 1'b1; pb_n = 1'b1;
    ticks(520); settle();
    chk_pwr("R3", 1'b1, 1'b0);

    // R5: short interrupt keeps minimum width
    pb_n = 1'b0; ticks(31); settle();
    chk_pwr("R5", 1'b1, 1'b0);
    ticks(1); settle();
    chk_pwr("R5", 1'b1, 1'b1);
    ticks(3); settle();
    pb_n = 1'b1;
    ticks(28); settle();
    chk_pwr("R5", 1'b1, 1'b1);
    ticks(1); settle();
    chk_pwr("R5", 1'b1, 1'b0);

    // R5: sub-threshold pulses on either input while on
    for (int i = 0; i < 8; i++) begin
      if ($urandom % 2) pb_n = 1'b0; else uv_n = 1'b0;
      ticks(1 + ($urandom % 30)); settle();
      pb_n = 1'b1; uv_n = 1'b1;
      ticks(2); settle();
      chk_pwr("R5", 1'b1, 1'b0);
    end

    // R5: interrupt follows a long hold
    extra = 12'd100;
    pb_n = 1'b0; ticks(100); settle();
    chk_pwr("R5", 1'b1, 1'b1);
    pb_n = 1'b1; ticks(1); settle();
    chk_pwr("R5", 1'b1, 1'b0);

    // R6/R7: undervoltage owns, button ignored, forced off at 64+20
    extra = 12'd20;
    uv_n = 1'b0; ticks(10); settle();
    pb_n = 1'b0; ticks(30); settle();
    chk_pwr("R5", 1'b1, 1'b1);
    pb_n = 1'b1; ticks(2); settle();
    chk_pwr("R7", 1'b1, 1'b1);
    ticks(41); settle();
    chk_pwr("R6", 1'b1, 1'b1);
    ticks(1); settle();
    chk_pwr("R6", 1'b0, 1'b0);

    // R8: low supply blocks power-on
    pb_n = 1'b0; ticks(130); settle();
    chk_pwr("R8", 1'b0, 1'b0);
    uv_n = 1'b1; ticks(31); settle();
    chk_pwr("R8", 1'b0, 1'b0);
    ticks(1); settle();
    chk_pwr("R8", 1'b1, 1'b0);
    pb_n = 1'b1;
    ticks(515); settle();
    chk_pwr("R3", 1'b1, 1'b0);

    // R7: simultaneous claim goes to button
    pb_n = 1'b0; uv_n = 1'b0; ticks(5); settle();
    uv_n = 1'b1; ticks(30); settle();
    chk_pwr("R7", 1'b1, 1'b1);
    pb_n = 1'b1; ticks(40); settle();
    chk_pwr("R7", 1'b1, 1'b0);

    // R4: kill during normal operation
    kill_n = 1'b0;
    repeat (5) @(negedge clk);
    chk_pwr("R4", 1'b0, 1'b0);
    kill_n = 1'b1;

    // R6: zero extra gives exactly 64
    pb_n = 1'b0; ticks(96); settle();
    chk_pwr("R2", 1'b1, 1'b0);
    pb_n = 1'b1; ticks(513); settle();
    chk_pwr("R3", 1'b1, 1'b0);
    extra = '0;
    pb_n = 1'b0; ticks(63); settle();
    chk_pwr("R6", 1'b1, 1'b1);
    ticks(1); settle();
    chk_pwr("R6", 1'b0, 1'b0);
    pb_n = 1'b1;
  endtask

  initial begin
    void'($urandom(32'd1234));
    fork
      run();
      begin
        repeat (WD_CYC) @(posedge clk);
        wd_hit = 1'b1;
      end
    join_any
    disable fork;
    if (wd_hit) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog act=expired exp=finished");
    end
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule